// File: doc/BRIEF.md
# Line-Serial Tape Controller Interface

This block sits between a processor's I/O bus and a two-drive line-serial tape transport. The processor issues I/O pulses with a 3-bit code and a 12-bit accumulator value. Each pulse tests a flag for a skip, loads the command or data register, or returns the status or data word. The response to a pulse is combinational and comes back in the same cycle. Any state change the pulse causes takes effect at the next clock edge.

The drive delivers one strobe per tape line, with a mark-track bit and a 3-bit data nibble. A strobe is accepted only when it comes from the selected unit. An accepted strobe shifts the nibble into the data register and the mark bit into the mark register. It sets the single-line flag and advances a modulo-4 line counter.

The processor moves one 12-bit word for every four lines. Every fourth line raises the quad-line flag. If that flag is still set when the next fourth line arrives, the word was lost. The block then raises a timing error and leaves write mode. In write mode the block presents the top nibble of the data register to the drive on each accepted line. Motion control and tape formatting are outside the block; it only reports significant command changes to them.

Top module: `tlc_iface`

## Requirements
- R1: After a synchronous reset, the command, data and mark registers, the line counter and all flags are zero. Status and data reads then return 0, and no skip is requested.
- R2: With `io_valid` high, codes 1, 2 and 3 raise `io_skip` when the single-line flag, the timing-error flag or the quad-line flag, respectively, is set. `io_skip` is low whenever `io_valid` is low.
- R3: Code 4 loads the command from accumulator bits 11:8 and clears the timing error. The field meanings are: bit 11 = unit (0 or 1), bit 10 = direction, bit 9 = go, bit 8 = write (1 = write). `cmd_new` pulses in that cycle when bit 11, 10 or 9 differs from the stored command, and only then; a change of bit 8 alone does not raise it. A `cmd_new` pulse clears the mark register.
- R4: Code 5 loads the full 12-bit accumulator into the data register. Codes 5, 6 and 7 each clear the single-line flag, the quad-line flag and the line counter.
- R5: Code 6 returns the status word. Bits 11:8 are the command, bits 5:0 are the mark register, and bit 7 is the write-lock input of the selected unit. Bit 6 is set on a timing error or when the selected unit is absent. Code 7 returns the data register. Every other code returns 0 on `io_rdata`.
- R6: Each accepted line sets the single-line flag and advances the line counter modulo 4. When the counter wraps to 0, the quad-line flag is set if it was clear. If it was already set, the timing error is set and the command's write bit is cleared.
- R7: Each accepted line shifts the mark register left by one bit, taking the mark bit in at bit 0 and keeping 6 bits. It also shifts the data register left by 3 bits, taking the nibble in at bits 2:0 and keeping 12 bits.
- R8: On an accepted line, `wr_stb` is high exactly when the write bit is set. `wr_nib` carries data bits 11:9 as they stand before that line's shift.
- R9: A line strobe whose `line_unit` differs from the command's unit bit changes no register and no flag.
- R10: When a pulse and an accepted line fall in the same cycle, the read value reflects the state before the cycle. The pulse's register effects are applied first and the line's effects on top of them, so the line sets the single-line flag again after a flag-clearing pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_valid | input | 1 | I/O pulse present this cycle |
| io_code | input | 3 | I/O pulse code |
| io_acc | input | 12 | Accumulator value for load pulses |
| io_skip | output | 1 | Skip request for codes 1 to 3 |
| io_rdata | output | 12 | Status or data word returned to the processor |
| cmd_unit | output | 1 | Selected unit |
| cmd_dir | output | 1 | Direction command |
| cmd_go | output | 1 | Stop/go command |
| cmd_write | output | 1 | Write mode |
| cmd_new | output | 1 | Significant command change, one cycle |
| line_stb | input | 1 | One tape line passed the head |
| line_unit | input | 1 | Unit that produced the line |
| line_mark | input | 1 | Mark-track bit of the line |
| line_nib | input | 3 | Data nibble read from the line |
| wr_stb | output | 1 | Write nibble valid for this line |
| wr_nib | output | 3 | Nibble to be written to tape |
| unit_present | input | 2 | Per-unit drive present |
| unit_wlock | input | 2 | Per-unit write lock |

## Verification
The bench builds the block with its default parameters: 12-bit words, 3-bit nibbles, a 6-bit mark register, four lines per word and two units. At that size the full command field can be swept against every combination of presence and write-lock inputs. The status word and the new-command pulse are checked on each step. Dozens of data words are then shifted through four-line groups with arithmetically predicted nibbles and mark patterns. The bench steps the line counter one line at a time to reach the exact wrap on which the quad flag or the timing error must appear.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    localparam int TLC_WORD_W = 12;
    localparam int TLC_NIB_W  = 3;
    localparam int TLC_MARK_W = 6;
    localparam int TLC_CMD_W  = 4;
    localparam int TLC_UNITS  = 2;

    // bit positions inside the 4-bit command field (word bits 11:8)
    localparam int CF_UNIT  = 3;
    localparam int CF_DIR   = 2;
    localparam int CF_GO    = 1;
    localparam int CF_WRITE = 0;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_SKIP_LINE = 3'd1,
        OP_SKIP_ERR  = 3'd2,
        OP_SKIP_QUAD = 3'd3,
        OP_LOAD_CMD  = 3'd4,
        OP_LOAD_DAT  = 3'd5,
        OP_READ_STAT = 3'd6,
        OP_READ_DAT  = 3'd7
    } tlc_op_e;

    typedef struct packed {
        logic skip_line;
        logic skip_err;
        logic skip_quad;
        logic load_cmd;
        logic load_dat;
        logic read_stat;
        logic read_dat;
    } tlc_ops_t;

endpackage

// File: rtl/tlc_pulse_decode.sv
module tlc_pulse_decode
    import tlc_pkg::*;
(
    input  logic     valid_i,
    input  logic [2:0] code_i,
    output tlc_ops_t ops_o
);

    always_comb begin
        ops_o = '0;
        if (valid_i) begin
            case (tlc_op_e'(code_i))
                OP_SKIP_LINE: ops_o.skip_line = 1'b1;
                OP_SKIP_ERR:  ops_o.skip_err  = 1'b1;
                OP_SKIP_QUAD: ops_o.skip_quad = 1'b1;
                OP_LOAD_CMD:  ops_o.load_cmd  = 1'b1;
                OP_LOAD_DAT:  ops_o.load_dat  = 1'b1;
                OP_READ_STAT: ops_o.read_stat = 1'b1;
                OP_READ_DAT:  ops_o.read_dat  = 1'b1;
                default:      ops_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/tlc_cmd_reg.sv
module tlc_cmd_reg
    import tlc_pkg::*;
#(
    parameter int CMD_W = TLC_CMD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CMD_W-1:0] cmd_in_i,
    input  logic             drop_write_i,
    output logic [CMD_W-1:0] cmd_o,
    output logic             new_cmd_o
);

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
    } cmd_state_t;

    cmd_state_t st_d, st_q;
    logic [CMD_W-1:0] diff;

    always_comb begin
        st_d = st_q;
        diff = (cmd_in_i ^ st_q.cmd) & ~(CMD_W'(1) << CF_WRITE);
        new_cmd_o = load_i && (diff != '0);
        if (load_i) begin
            st_d.cmd = cmd_in_i;
        end
        if (drop_write_i) begin
            st_d.cmd[CF_WRITE] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o = st_q.cmd;

    AST_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        drop_write_i |=> !cmd_o[CF_WRITE]) else $error("write kept after loss"); // R6

    AST_CMD_LOADED: assert property (@(posedge clk) disable iff (rst)
        (load_i && !drop_write_i) |=> (cmd_o == $past(cmd_in_i))) else $error("command not stored"); // R3

endmodule

// File: rtl/tlc_line_engine.sv
module tlc_line_engine
    import tlc_pkg::*;
#(
    parameter int WORD_W = TLC_WORD_W,
    parameter int NIB_W  = TLC_NIB_W,
    parameter int MARK_W = TLC_MARK_W,
    parameter int LPW    = WORD_W / NIB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_flags_i,
    input  logic              clr_err_i,
    input  logic              clr_mark_i,
    input  logic              load_dat_i,
    input  logic [WORD_W-1:0] acc_i,
    input  logic              line_i,
    input  logic              mark_i,
    input  logic [NIB_W-1:0]  nib_i,
    output logic [WORD_W-1:0] dat_o,
    output logic [MARK_W-1:0] mark_o,
    output logic              line_flag_o,
    output logic              quad_flag_o,
    output logic              err_o,
    output logic              err_set_o,
    output logic [NIB_W-1:0]  wr_nib_o
);

    localparam int CNT_W = (LPW > 1) ? $clog2(LPW) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LPW - 1);

    typedef struct packed {
        logic [WORD_W-1:0] dat;
        logic [MARK_W-1:0] mark;
        logic [CNT_W-1:0]  cnt;
        logic              line_flag;
        logic              quad_flag;
        logic              err;
    } eng_state_t;

    eng_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        err_set_o = 1'b0;
        // pulse effects first
        if (clr_flags_i) begin
            st_d.line_flag = 1'b0;
            st_d.quad_flag = 1'b0;
            st_d.cnt       = '0;
        end
        if (clr_err_i) begin
            st_d.err = 1'b0;
        end
        if (load_dat_i) begin
            st_d.dat = acc_i;
        end
        if (clr_mark_i) begin
            st_d.mark = '0;
        end
        wr_nib_o = st_d.dat[WORD_W-1 -: NIB_W];
        // then the line on top
        if (line_i) begin
            st_d.line_flag = 1'b1;
            if (st_d.cnt == CNT_LAST) begin
                st_d.cnt = '0;
                if (st_d.quad_flag) begin
                    st_d.err  = 1'b1;
                    err_set_o = 1'b1;
                end else begin
                    st_d.quad_flag = 1'b1;
                end
            end else begin
                st_d.cnt = st_d.cnt + 1'b1;
            end
            st_d.mark = {st_d.mark[MARK_W-2:0], mark_i};
            st_d.dat  = {st_d.dat[WORD_W-NIB_W-1:0], nib_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dat_o       = st_q.dat;
    assign mark_o      = st_q.mark;
    assign line_flag_o = st_q.line_flag;
    assign quad_flag_o = st_q.quad_flag;
    assign err_o       = st_q.err;

    AST_LINE_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        line_i |=> line_flag_o) else $error("line flag not set"); // R6

    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (clr_flags_i && !line_i) |=> (!line_flag_o && !quad_flag_o)) else $error("flags survive clear"); // R4

    AST_MARK_SHIFT: assert property (@(posedge clk) disable iff (rst)
        line_i |=> (mark_o[0] == $past(mark_i))) else $error("mark bit lost"); // R7

    AST_DATA_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (line_i && !load_dat_i) |=>
            (dat_o == {$past(dat_o[WORD_W-NIB_W-1:0]), $past(nib_i)})) else $error("data shift wrong"); // R7

    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (clr_err_i && !line_i) |=> !err_o) else $error("error survives command load"); // R3

    AST_MARK_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (clr_mark_i && !line_i) |=> (mark_o == '0)) else $error("mark survives new command"); // R3

endmodule

// File: rtl/tlc_iface.sv
module tlc_iface
    import tlc_pkg::*;
#(
    parameter int WORD_W = TLC_WORD_W,
    parameter int NIB_W  = TLC_NIB_W,
    parameter int MARK_W = TLC_MARK_W,
    parameter int UNITS  = TLC_UNITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_valid,
    input  logic [2:0]        io_code,
    input  logic [WORD_W-1:0] io_acc,
    output logic              io_skip,
    output logic [WORD_W-1:0] io_rdata,
    output logic              cmd_unit,
    output logic              cmd_dir,
    output logic              cmd_go,
    output logic              cmd_write,
    output logic              cmd_new,
    input  logic              line_stb,
    input  logic              line_unit,
    input  logic              line_mark,
    input  logic [NIB_W-1:0]  line_nib,
    output logic              wr_stb,
    output logic [NIB_W-1:0]  wr_nib,
    input  logic [UNITS-1:0]  unit_present,
    input  logic [UNITS-1:0]  unit_wlock
);

    localparam int CMD_W = TLC_CMD_W;
    localparam int LPW   = WORD_W / NIB_W;

    tlc_ops_t          ops;
    logic [CMD_W-1:0]  cmd_q;
    logic              new_cmd;
    logic              line_sel;
    logic              err_set;
    logic [WORD_W-1:0] dat_q;
    logic [MARK_W-1:0] mark_q;
    logic              line_flag_q, quad_flag_q, err_q;
    logic [WORD_W-1:0] status;
    logic              sel_err;

    tlc_pulse_decode u_decode (
        .valid_i (io_valid),
        .code_i  (io_code),
        .ops_o   (ops)
    );

    tlc_cmd_reg #(.CMD_W(CMD_W)) u_cmd (
        .clk          (clk),
        .rst          (rst),
        .load_i       (ops.load_cmd),
        .cmd_in_i     (io_acc[WORD_W-1 -: CMD_W]),
        .drop_write_i (err_set),
        .cmd_o        (cmd_q),
        .new_cmd_o    (new_cmd)
    );

    assign line_sel = line_stb && (line_unit == cmd_q[CF_UNIT]);

    tlc_line_engine #(
        .WORD_W (WORD_W),
        .NIB_W  (NIB_W),
        .MARK_W (MARK_W),
        .LPW    (LPW)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .clr_flags_i (ops.load_dat | ops.read_stat | ops.read_dat),
        .clr_err_i   (ops.load_cmd),
        .clr_mark_i  (new_cmd),
        .load_dat_i  (ops.load_dat),
        .acc_i       (io_acc),
        .line_i      (line_sel),
        .mark_i      (line_mark),
        .nib_i       (line_nib),
        .dat_o       (dat_q),
        .mark_o      (mark_q),
        .line_flag_o (line_flag_q),
        .quad_flag_o (quad_flag_q),
        .err_o       (err_q),
        .err_set_o   (err_set),
        .wr_nib_o    (wr_nib)
    );

    always_comb begin
        sel_err                         = err_q || !unit_present[cmd_q[CF_UNIT]];
        status                          = '0;
        status[WORD_W-1 -: CMD_W]       = cmd_q;
        status[MARK_W-1:0]              = mark_q;
        status[MARK_W]                  = sel_err;
        status[MARK_W+1]                = unit_wlock[cmd_q[CF_UNIT]];
        io_skip = (ops.skip_line & line_flag_q)
                | (ops.skip_err  & err_q)
                | (ops.skip_quad & quad_flag_q);
        if (ops.read_stat) begin
            io_rdata = status;
        end else if (ops.read_dat) begin
            io_rdata = dat_q;
        end else begin
            io_rdata = '0;
        end
    end

    assign cmd_unit  = cmd_q[CF_UNIT];
    assign cmd_dir   = cmd_q[CF_DIR];
    assign cmd_go    = cmd_q[CF_GO];
    assign cmd_write = cmd_q[CF_WRITE];
    assign cmd_new   = new_cmd;
    assign wr_stb    = line_sel && cmd_q[CF_WRITE];

    AST_SKIP_NEEDS_PULSE: assert property (@(posedge clk) disable iff (rst)
        io_skip |-> io_valid) else $error("skip without pulse"); // R2

    AST_ERR_LEAVES_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> !cmd_write) else $error("write mode after timing error"); // R6

    AST_OTHER_UNIT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (line_stb && (line_unit != cmd_unit) && !io_valid) |=>
            ($stable(dat_q) && $stable(mark_q) && $stable(line_flag_q))) else $error("foreign line accepted"); // R9

endmodule

// File: tb/tlc_iface_test.sv
module tlc_iface_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        io_valid;
    logic [2:0]  io_code;
    logic [11:0] io_acc;
    logic        io_skip;
    logic [11:0] io_rdata;
    logic        cmd_unit, cmd_dir, cmd_go, cmd_write, cmd_new;
    logic        line_stb, line_unit, line_mark;
    logic [2:0]  line_nib;
    logic        wr_stb;
    logic [2:0]  wr_nib;
    logic [1:0]  unit_present, unit_wlock;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic        c_skip, c_new, c_wstb;
    logic [11:0] c_rdata;
    logic [2:0]  c_wnib;

    always #10 clk = ~clk;

    tlc_iface uut (
        .clk(clk), .rst(rst), .io_valid(io_valid), .io_code(io_code), .io_acc(io_acc),
        .io_skip(io_skip), .io_rdata(io_rdata), .cmd_unit(cmd_unit), .cmd_dir(cmd_dir),
        .cmd_go(cmd_go), .cmd_write(cmd_write), .cmd_new(cmd_new), .line_stb(line_stb),
        .line_unit(line_unit), .line_mark(line_mark), .line_nib(line_nib), .wr_stb(wr_stb),
        .wr_nib(wr_nib), .unit_present(unit_present), .unit_wlock(unit_wlock)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%o expected=%o", req, act, exp);
        end
    endtask

    task automatic cyc(input logic pv, input logic [2:0] pc, input logic [11:0] acc,
                       input logic ls, input logic lu, input logic mb, input logic [2:0] nb);
        @(negedge clk);
        io_valid = pv; io_code = pc; io_acc = acc;
        line_stb = ls; line_unit = lu; line_mark = mb; line_nib = nb;
        #2;
        c_skip = io_skip; c_rdata = io_rdata; c_new = cmd_new;
        c_wstb = wr_stb; c_wnib = wr_nib;
        @(posedge clk);
        #1;
        io_valid = 1'b0; line_stb = 1'b0;
    endtask

    task automatic io(input logic [2:0] code, input logic [11:0] acc);
        cyc(1'b1, code, acc, 1'b0, 1'b0, 1'b0, 3'd0);
    endtask

    task automatic ln(input logic unit, input logic mb, input logic [2:0] nb);
        cyc(1'b0, 3'd0, 12'd0, 1'b1, unit, mb, nb);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [3:0]  prev;
        logic [11:0] cur;
        logic [5:0]  curm;
        logic [11:0] st0;
        logic [11:0] d;
        logic [2:0]  nb;
        logic        mb;
        logic        exp_err;
        io_valid = 0; io_code = 0; io_acc = 0;
        line_stb = 0; line_unit = 0; line_mark = 0; line_nib = 0;
        unit_present = 2'b11; unit_wlock = 2'b00;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check("R1 cmd outputs", {8'd0, cmd_unit, cmd_dir, cmd_go, cmd_write}, 12'd0);
        io(3'd6, 12'd0); check("R1 status", c_rdata, 12'd0);
        io(3'd7, 12'd0); check("R1 data", c_rdata, 12'd0);
        io(3'd1, 12'd0); check("R1 skip line", {11'd0, c_skip}, 12'd0);
        io(3'd2, 12'd0); check("R1 skip err", {11'd0, c_skip}, 12'd0);
        io(3'd3, 12'd0); check("R1 skip quad", {11'd0, c_skip}, 12'd0);

        // R3 / R5 sweep: command field x presence x write lock
        prev = 4'd0;
        for (int pw = 0; pw < 16; pw++) begin
            unit_present = pw[1:0];
            unit_wlock   = pw[3:2];
            for (int c = 0; c < 16; c++) begin
                io(3'd4, {c[3:0], 8'hA5});
                check("R3 new command pulse", {11'd0, c_new},
                      {11'd0, (((prev ^ c[3:0]) & 4'hE) != 4'd0)});
                prev = c[3:0];
                exp_err = !unit_present[c[3]];
                io(3'd6, 12'd0);
                check("R5 status word", c_rdata,
                      {c[3:0], unit_wlock[c[3]], exp_err, 6'd0});
            end
        end
        unit_present = 2'b11; unit_wlock = 2'b00;

        // R4 R7 R8: unit 0, go, write; shift words through
        io(3'd4, 12'o1400);
        check("R3 significant change", {11'd0, c_new}, 12'd1);
        curm = 6'd0;
        for (int t = 0; t < 32; t++) begin
            d = 12'((t * 12'o1234 + 12'o77) & 12'o7777);
            io(3'd5, d);
            io(3'd7, 12'd0);
            check("R4 load data", c_rdata, d);
            cur = d;
            for (int k = 0; k < 4; k++) begin
                nb = 3'((t + k * 3) & 7);
                mb = 1'((t >> k) & 1);
                ln(1'b0, mb, nb);
                check("R8 write strobe", {11'd0, c_wstb}, 12'd1);
                check("R8 write nibble", {9'd0, c_wnib}, {9'd0, cur[11:9]});
                cur  = {cur[8:0], nb};
                curm = {curm[4:0], mb};
            end
            io(3'd1, 12'd0); check("R6 line flag", {11'd0, c_skip}, 12'd1);
            io(3'd3, 12'd0); check("R6 quad flag", {11'd0, c_skip}, 12'd1);
            io(3'd6, 12'd0); check("R7 mark register", {6'd0, c_rdata[5:0]}, {6'd0, curm});
            io(3'd7, 12'd0); check("R7 data register", c_rdata, cur);
        end

        // R4 clears, R6 counter and timing error
        io(3'd3, 12'd0); check("R4 quad cleared", {11'd0, c_skip}, 12'd0);
        for (int k = 0; k < 3; k++) ln(1'b0, 1'b0, 3'd0);
        io(3'd3, 12'd0); check("R6 no quad at 3 lines", {11'd0, c_skip}, 12'd0);
        ln(1'b0, 1'b0, 3'd0);
        io(3'd3, 12'd0); check("R6 quad at 4 lines", {11'd0, c_skip}, 12'd1);
        for (int k = 0; k < 3; k++) ln(1'b0, 1'b1, 3'd0);
        io(3'd2, 12'd0); check("R6 no error at 7 lines", {11'd0, c_skip}, 12'd0);
        ln(1'b0, 1'b1, 3'd0);
        io(3'd2, 12'd0); check("R6 error at 8 lines", {11'd0, c_skip}, 12'd1);
        check("R6 write left", {11'd0, cmd_write}, 12'd0);
        io(3'd6, 12'd0); check("R6 status err no write", c_rdata & 12'o7700, 12'o1100);
        ln(1'b0, 1'b0, 3'd0);
        check("R8 no strobe in read", {11'd0, c_wstb}, 12'd0);
        io(3'd4, 12'o1000);
        check("R3 same command no pulse", {11'd0, c_new}, 12'd0);
        io(3'd2, 12'd0); check("R3 error cleared", {11'd0, c_skip}, 12'd0);
        io(3'd4, 12'o1400);
        check("R3 write-only change no pulse", {11'd0, c_new}, 12'd0);

        // R9 foreign unit
        io(3'd5, 12'o5252);
        io(3'd6, 12'd0); st0 = c_rdata;
        ln(1'b1, 1'b1, 3'd7);
        check("R9 no write strobe", {11'd0, c_wstb}, 12'd0);
        io(3'd1, 12'd0); check("R9 line flag", {11'd0, c_skip}, 12'd0);
        io(3'd6, 12'd0); check("R9 status", c_rdata, st0);
        io(3'd7, 12'd0); check("R9 data", c_rdata, 12'o5252);

        // R10 pulse and line together
        io(3'd5, 12'o1111);
        cyc(1'b1, 3'd7, 12'd0, 1'b1, 1'b0, 1'b1, 3'd5);
        check("R10 read before line", c_rdata, 12'o1111);
        io(3'd1, 12'd0); check("R10 line flag after clear", {11'd0, c_skip}, 12'd1);
        io(3'd7, 12'd0); check("R10 data after line", c_rdata, 12'o1115);

        // R2 skip needs a valid pulse; R5 other codes read 0
        ln(1'b0, 1'b0, 3'd1);
        cyc(1'b0, 3'd1, 12'd0, 1'b0, 1'b0, 1'b0, 3'd0);
        check("R2 no skip without pulse", {11'd0, c_skip}, 12'd0);
        io(3'd1, 12'd0);
        check("R2 skip on line flag", {11'd0, c_skip}, 12'd1);
        check("R5 zero on skip code", c_rdata, 12'd0);
        io(3'd0, 12'o7777);
        check("R5 zero on code 0", c_rdata, 12'd0);

        summary();
        done = 1;
        $finish;
    end

endmodule